// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

The engine walks a ring of transmit buffer descriptors kept in system memory and streams the bytes each descriptor points at to a MAC transmit port, one byte per handshake. Software fills descriptors, marks them as owned by hardware and pulses `kick`. The engine then fetches descriptors from the current ring position. For each one it sends the buffer and writes the status word back with the ownership bit cleared. It moves on to the next descriptor and stops once it reads a descriptor that software still owns. CRC generation and the MAC itself sit outside the block. The engine only flags, on the final byte of a frame, whether the MAC should append a CRC.

A descriptor occupies two consecutive 32-bit words. The first word holds the status in bits [15:0] and the buffer length in bytes in bits [31:16]. The second word holds the buffer byte address. Status flags are bit 15 (owned by hardware), bit 13 (return to the ring base after this descriptor), bit 10 (request a CRC) and bit 11 (final buffer of the frame). Descriptors are 8 bytes apart. Software can ask for a stop between frames with `graceful_stop`. Dropping `enable` aborts any activity and moves the ring position back to `ring_base`.

Both data paths are valid/ready. On the memory port, `mem_valid` stays asserted with address, direction and write data unchanged until `mem_ready`. Read data is taken from `mem_rdata` in the cycle in which `mem_valid` and `mem_ready` are both high. On the byte port, `tx_valid` stays asserted with `tx_data`, `tx_last` and `tx_crc` unchanged until `tx_ready`. A byte counts as sent in a cycle in which both are high. Either side may hold its ready low for any number of cycles.

Top module: `txd_engine`

## Requirements
- R1: While and after reset, `active`, `stop_done`, `mem_valid` and `tx_valid` are low.
- R2: With `enable` high, a `kick` pulse raises `active` on the next edge. The first memory access is then a read of the descriptor status word at the current ring position, which is `ring_base` after reset.
- R3: The buffer bytes go out in ascending address order and any byte alignment of the pointer is accepted. The byte at address a is taken from bits [8*(a mod 4)+7 : 8*(a mod 4)] of the word at a rounded down to a multiple of 4. Exactly `length` bytes are sent, with `length` at least 1.
- R4: `tx_last` is high only on the final byte of a descriptor whose status bit 11 is set. On that byte `tx_crc` equals status bit 10. At all other times `tx_crc` is low.
- R5: Once the final byte of a buffer has been accepted, the engine writes the descriptor's first word back with bit 15 cleared. The other status bits and the length are written back unchanged.
- R6: After the write-back, the next descriptor is fetched 8 bytes further on. If the finished descriptor had status bit 13 set, the next fetch is at `ring_base` instead.
- R7: `active` falls only after a completed status read that finds bit 15 clear, and that read follows the previous write-back. A single descriptor marked both owned and wrapping is therefore sent exactly once per `kick`.
- R8: While `graceful_stop` is high, the engine finishes the frame in progress, including any further buffers up to and including the one with bit 11 set, and then starts no new frame. `active` falls, `stop_done` goes high and stays high until `graceful_stop` is lowered. A later `kick` resumes at the descriptor that was not started.
- R9: With `enable` low the engine is idle: `active`, `tx_valid` and `mem_valid` are low within one cycle and `kick` has no effect. After `enable` returns high, the next fetch is at `ring_base`, and a descriptor whose transfer was cut off is not written back.
- R10: The memory request and the byte output each stay valid with stable contents until the other side accepts them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Controller enable; low aborts and moves the ring position back to the base |
| ring_base | input | ADDR_W | Byte address of the first descriptor |
| kick | input | 1 | One-cycle pulse that starts descriptor processing |
| graceful_stop | input | 1 | Request to halt at the next frame boundary |
| active | output | 1 | Descriptor processing in progress |
| stop_done | output | 1 | Graceful stop has taken effect |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request; read data valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | MAC accepts the byte |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_crc | output | 1 | CRC append request, meaningful with `tx_last` |

## Verification
The handshake properties assume that memory returns read data in the cycle of `mem_ready` and that the engine may drop a pending request only while `enable` is low. That abort case is excluded from the properties. The properties also assume software writes descriptors with a length of at least one and keeps buffers apart from the ring. The bench models memory as a combinational word array and throttles `mem_ready` and `tx_ready` with fixed stall patterns. It writes descriptors only while the engine is idle, uses nonzero lengths, and holds `graceful_stop` high until `stop_done` has been observed.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int WORD_W   = 32;
  localparam int LEN_W    = 16;
  localparam int STAT_W   = WORD_W - LEN_W;
  localparam int LANES    = WORD_W / 8;
  localparam int LANE_SEL = $clog2(LANES);
  localparam int OWN_BIT  = 15;
  localparam int WRAP_BIT = 13;
  localparam int LAST_BIT = 11;
  localparam int CRC_BIT  = 10;
  localparam int DESC_BYTES = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_STAT, ST_PTR, ST_DATA, ST_SEND, ST_WB
  } seq_state_t;
endpackage

// File: rtl/txd_ring_ptr.sv
module txd_ring_ptr
  import txd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              advance,
  input  logic              wrap,
  input  logic [ADDR_W-1:0] ring_base,
  output logic [ADDR_W-1:0] desc_addr
);
  logic [OFS_W-1:0] ofs_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) ofs_q <= '0;
    else if (advance)      ofs_q <= wrap ? '0 : ofs_q + OFS_W'(DESC_BYTES);
  end

  assign desc_addr = ring_base + ADDR_W'(ofs_q);
endmodule

// File: rtl/txd_byte_pack.sv
module txd_byte_pack
  import txd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_ptr,
  input  logic [ADDR_W-1:0] ptr_in,
  input  logic [LEN_W-1:0]  len_in,
  input  logic              load_word,
  input  logic [WORD_W-1:0] word_in,
  input  logic              take,
  output logic [7:0]        byte_out,
  output logic [ADDR_W-1:0] word_addr,
  output logic              rem_one,
  output logic              word_end
);
  logic [ADDR_W-1:0] baddr_q;
  logic [LEN_W-1:0]  remain_q;
  logic [WORD_W-1:0] word_q;
  logic [7:0]        lane [LANES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      baddr_q  <= '0;
      remain_q <= '0;
      word_q   <= '0;
    end else begin
      if (load_ptr) begin
        baddr_q  <= ptr_in;
        remain_q <= len_in;
      end else if (take) begin
        baddr_q  <= baddr_q + ADDR_W'(1);
        remain_q <= remain_q - LEN_W'(1);
      end
      if (load_word) word_q <= word_in;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = word_q[8*g +: 8];
  end

  assign byte_out  = lane[baddr_q[LANE_SEL-1:0]];
  assign word_addr = {baddr_q[ADDR_W-1:LANE_SEL], {LANE_SEL{1'b0}}};
  assign rem_one   = (remain_q == LEN_W'(1));
  assign word_end  = (baddr_q[LANE_SEL-1:0] == {LANE_SEL{1'b1}});

  // R3: a byte is only consumed while buffer bytes remain
  p_take_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> remain_q != '0);
endmodule

// File: rtl/txd_seq.sv
module txd_seq
  import txd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              kick,
  input  logic              graceful_stop,
  output logic              active,
  output logic              stop_done,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              tx_last,
  output logic              tx_crc,
  input  logic [ADDR_W-1:0] desc_addr,
  input  logic [ADDR_W-1:0] word_addr,
  input  logic              rem_one,
  input  logic              word_end,
  output logic              advance,
  output logic              wrap,
  output logic              load_ptr,
  output logic              load_word,
  output logic              take,
  output logic [LEN_W-1:0]  len_out
);
  seq_state_t        state;
  logic [STAT_W-1:0] stat_q;
  logic [LEN_W-1:0]  len_q;
  logic              in_frame;
  logic              mem_fire, tx_fire;

  assign mem_valid = (state == ST_STAT) || (state == ST_PTR) ||
                     (state == ST_DATA) || (state == ST_WB);
  assign mem_we    = (state == ST_WB);
  assign mem_wdata = {len_q, stat_q & ~(STAT_W'(1) << OWN_BIT)};
  assign mem_fire  = mem_valid && mem_ready;
  assign tx_valid  = (state == ST_SEND);
  assign tx_fire   = tx_valid && tx_ready;
  assign tx_last   = tx_valid && rem_one && stat_q[LAST_BIT];
  assign tx_crc    = tx_last && stat_q[CRC_BIT];
  assign advance   = (state == ST_WB) && mem_fire;
  assign wrap      = stat_q[WRAP_BIT];
  assign load_ptr  = (state == ST_PTR) && mem_fire;
  assign load_word = (state == ST_DATA) && mem_fire;
  assign take      = tx_fire;
  assign len_out   = len_q;

  always_comb begin
    case (state)
      ST_STAT, ST_WB: mem_addr = desc_addr;
      ST_PTR:         mem_addr = desc_addr + ADDR_W'(4);
      ST_DATA:        mem_addr = word_addr;
      default:        mem_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      active    <= 1'b0;
      in_frame  <= 1'b0;
      stat_q    <= '0;
      len_q     <= '0;
      stop_done <= 1'b0;
    end else begin
      stop_done <= graceful_stop && (state == ST_IDLE);
      if (!enable) begin
        state    <= ST_IDLE;
        active   <= 1'b0;
        in_frame <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: if (kick) begin
            state  <= ST_STAT;
            active <= 1'b1;
          end
          ST_STAT: if (mem_fire) begin
            if (!mem_rdata[OWN_BIT] || (graceful_stop && !in_frame)) begin
              state  <= ST_IDLE;
              active <= 1'b0;
            end else begin
              stat_q <= mem_rdata[STAT_W-1:0];
              len_q  <= mem_rdata[WORD_W-1:STAT_W];
              state  <= ST_PTR;
            end
          end
          ST_PTR:  if (mem_fire) state <= ST_DATA;
          ST_DATA: if (mem_fire) state <= ST_SEND;
          ST_SEND: if (tx_fire) begin
            if (rem_one)       state <= ST_WB;
            else if (word_end) state <= ST_DATA;
          end
          ST_WB: if (mem_fire) begin
            in_frame <= !stat_q[LAST_BIT];
            state    <= ST_STAT;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R10: a memory request is held unchanged until accepted
  p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n || !enable)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) &&
                                $stable(mem_we) && $stable(mem_wdata));
  // R10: an output byte is held unchanged until accepted
  p_tx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n || !enable)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_last) && $stable(tx_crc));
  // R5: every write-back hands ownership back to software
  p_wb_clears_own_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we |-> !mem_wdata[OWN_BIT]);
  // R7: active only falls right after a completed status read
  p_drop_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) && $past(enable) |-> $past(mem_valid && mem_ready && !mem_we));
  // R4: the CRC request only comes with the end of a frame
  p_crc_with_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_crc |-> tx_last && tx_valid);
  // R8: the stop is reported only once the engine has gone idle
  p_stop_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_done) |-> $past(!active));
endmodule

// File: rtl/txd_engine.sv
module txd_engine
  import txd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic              kick,
  input  logic              graceful_stop,
  output logic              active,
  output logic              stop_done,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  output logic              tx_crc
);
  logic [ADDR_W-1:0] desc_addr, word_addr;
  logic              rem_one, word_end, advance, wrap;
  logic              load_ptr, load_word, take;
  logic [LEN_W-1:0]  len_w;

  txd_ring_ptr #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) i_ring (
    .clk(clk), .rst_n(rst_n), .enable(enable), .advance(advance),
    .wrap(wrap), .ring_base(ring_base), .desc_addr(desc_addr)
  );

  txd_byte_pack #(.ADDR_W(ADDR_W)) i_pack (
    .clk(clk), .rst_n(rst_n), .load_ptr(load_ptr),
    .ptr_in(mem_rdata[ADDR_W-1:0]), .len_in(len_w),
    .load_word(load_word), .word_in(mem_rdata), .take(take),
    .byte_out(tx_data), .word_addr(word_addr), .rem_one(rem_one),
    .word_end(word_end)
  );

  txd_seq #(.ADDR_W(ADDR_W)) i_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .kick(kick),
    .graceful_stop(graceful_stop), .active(active), .stop_done(stop_done),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_last(tx_last),
    .tx_crc(tx_crc), .desc_addr(desc_addr), .word_addr(word_addr),
    .rem_one(rem_one), .word_end(word_end), .advance(advance), .wrap(wrap),
    .load_ptr(load_ptr), .load_word(load_word), .take(take), .len_out(len_w)
  );
endmodule

// File: tb/test_txd_engine.sv
module test_txd_engine;
  localparam logic [15:0] OWN = 16'h8000, WRP = 16'h2000, LST = 16'h0800, CRC = 16'h0400;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b1, kick = 1'b0, graceful_stop = 1'b0;
  logic [31:0] ring_base = 32'h40;
  logic active, stop_done, mem_valid, mem_ready, mem_we, tx_valid, tx_ready, tx_last, tx_crc;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [7:0] tx_data;

  logic [31:0] mem [0:255];
  logic [7:0] cap_d [0:1023];
  logic cap_l [0:1023];
  logic cap_c [0:1023];
  int ncap = 0, tick = 0, total = 0, bad = 0;
  logic mem_slow = 1'b0, tx_slow = 1'b0, done = 1'b0;
  logic [7:0] exp_b [0:511];
  int exp_n;

  always #4 clk = ~clk;

  txd_engine i_txd_engine (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ring_base(ring_base), .kick(kick),
    .graceful_stop(graceful_stop), .active(active), .stop_done(stop_done),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last), .tx_crc(tx_crc)
  );

  assign mem_rdata = mem[mem_addr[9:2]];
  assign mem_ready = !(mem_slow && (tick % 3 == 0));
  assign tx_ready  = !(tx_slow && (tick % 4 == 1));

  always @(posedge clk) begin
    tick <= tick + 1;
    if (mem_valid && mem_ready && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    if (tx_valid && tx_ready) begin
      cap_d[ncap % 1024] <= tx_data;
      cap_l[ncap % 1024] <= tx_last;
      cap_c[ncap % 1024] <= tx_crc;
      ncap <= ncap + 1;
    end
  end

  function automatic logic [7:0] pat(int a);
    return 8'((a * 13 + 7) ^ (a >> 4));
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_desc(int a, logic [15:0] st, logic [15:0] len, logic [31:0] ptr);
    mem[a >> 2] <= {len, st};
    mem[(a >> 2) + 1] <= ptr;
    @(negedge clk);
  endtask

  task automatic exp_add(int ptr, int len);
    for (int k = 0; k < len; k++) begin
      exp_b[exp_n] = pat(ptr + k);
      exp_n++;
    end
  endtask

  task automatic do_kick(int want_addr, string req);
    @(negedge clk);
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
    chk(active === 1'b1, {req, " active after kick"}, active, 1);
    chk(mem_valid && !mem_we && mem_addr == want_addr, {req, " first status read address"},
        mem_addr, want_addr);
  endtask

  task automatic wait_idle(string req);
    int k = 0;
    while (active && k < 4000) begin
      @(negedge clk);
      k++;
    end
    chk(!active, {req, " engine went idle"}, active, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic cmp_stream(int start, bit want_crc, string req);
    chk(ncap - start == exp_n, {req, " byte count"}, ncap - start, exp_n);
    for (int k = 0; k < exp_n && k < ncap - start; k++) begin
      chk(cap_d[(start + k) % 1024] == exp_b[k], "R3 byte value/order", cap_d[(start + k) % 1024], exp_b[k]);
      chk(cap_l[(start + k) % 1024] == (k == exp_n - 1), "R4 tx_last placement",
          cap_l[(start + k) % 1024], k == exp_n - 1);
      chk(cap_c[(start + k) % 1024] == ((k == exp_n - 1) && want_crc), "R4 tx_crc value",
          cap_c[(start + k) % 1024], (k == exp_n - 1) && want_crc);
    end
  endtask

  task automatic restart_ring(logic [31:0] b);
    @(negedge clk);
    enable = 1'b0;
    ring_base = b;
    repeat (2) @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(!active && !stop_done && !mem_valid && !tx_valid, "R1 outputs in reset",
        {active, stop_done, mem_valid, tx_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!active && !stop_done && !mem_valid && !tx_valid, "R1 outputs after reset",
        {active, stop_done, mem_valid, tx_valid}, 0);
  endtask

  task automatic t_two_buffers;
    int s;
    mem_slow = 1'b1; tx_slow = 1'b1;
    set_desc(32'h40, OWN, 16'd5, 32'h100);
    set_desc(32'h48, OWN | LST | CRC, 16'd3, 32'h203);
    set_desc(32'h50, 16'h0000, 16'd0, 32'h0);
    exp_n = 0; exp_add(32'h100, 5); exp_add(32'h203, 3);
    s = ncap;
    do_kick(32'h40, "R2");
    wait_idle("R7");
    cmp_stream(s, 1'b1, "R3");
    chk(mem[32'h40 >> 2] == {16'd5, 16'h0000}, "R5 write-back of first descriptor",
        mem[32'h40 >> 2], {16'd5, 16'h0000});
    chk(mem[32'h48 >> 2] == {16'd3, LST | CRC}, "R6 next descriptor at +8 written back",
        mem[32'h48 >> 2], {16'd3, LST | CRC});
    mem_slow = 1'b0; tx_slow = 1'b0;
  endtask

  task automatic t_single_wrap;
    int s;
    restart_ring(32'h80);
    set_desc(32'h80, OWN | WRP | LST, 16'd4, 32'h140);
    exp_n = 0; exp_add(32'h140, 4);
    s = ncap;
    do_kick(32'h80, "R2");
    wait_idle("R7");
    repeat (20) @(negedge clk);
    cmp_stream(s, 1'b0, "R7 single wrapped descriptor sent once");
    chk(mem[32'h80 >> 2] == {16'd4, WRP | LST}, "R5 write-back keeps flags and length",
        mem[32'h80 >> 2], {16'd4, WRP | LST});
    set_desc(32'h80, OWN | WRP | LST | CRC, 16'd2, 32'h150);
    exp_n = 0; exp_add(32'h150, 2);
    s = ncap;
    do_kick(32'h80, "R6 wrap back to base");
    wait_idle("R7");
    cmp_stream(s, 1'b1, "R6");
  endtask

  task automatic t_graceful;
    int s;
    restart_ring(32'hC0);
    set_desc(32'hC0, OWN, 16'd6, 32'h180);
    set_desc(32'hC8, OWN | LST | CRC, 16'd2, 32'h1A1);
    set_desc(32'hD0, OWN | LST, 16'd3, 32'h1C0);
    set_desc(32'hD8, 16'h0000, 16'd0, 32'h0);
    exp_n = 0; exp_add(32'h180, 6); exp_add(32'h1A1, 2);
    s = ncap;
    do_kick(32'hC0, "R2");
    while (ncap == s) @(negedge clk);
    graceful_stop = 1'b1;
    wait_idle("R8");
    cmp_stream(s, 1'b1, "R8 frame in progress completed");
    chk(mem[32'hD0 >> 2] == {16'd3, OWN | LST}, "R8 next frame not started",
        mem[32'hD0 >> 2], {16'd3, OWN | LST});
    chk(stop_done === 1'b1, "R8 stop_done raised", stop_done, 1);
    graceful_stop = 1'b0;
    repeat (2) @(negedge clk);
    chk(stop_done === 1'b0, "R8 stop_done cleared", stop_done, 0);
    exp_n = 0; exp_add(32'h1C0, 3);
    s = ncap;
    do_kick(32'hD0, "R8 resume at unstarted descriptor");
    wait_idle("R8");
    cmp_stream(s, 1'b0, "R8");
  endtask

  task automatic t_abort;
    int s;
    restart_ring(32'hE0);
    set_desc(32'hE0, OWN | LST, 16'd2, 32'h220);
    set_desc(32'hE8, OWN | LST, 16'd40, 32'h240);
    tx_slow = 1'b1;
    s = ncap;
    do_kick(32'hE0, "R2");
    while (ncap < s + 5) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk(!active && !tx_valid && !mem_valid, "R9 idle after disable",
        {active, tx_valid, mem_valid}, 0);
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
    @(negedge clk);
    chk(!active, "R9 kick ignored while disabled", active, 0);
    enable = 1'b1;
    tx_slow = 1'b0;
    chk(mem[32'hE8 >> 2] == {16'd40, OWN | LST}, "R9 cut-off descriptor not written back",
        mem[32'hE8 >> 2], {16'd40, OWN | LST});
    s = ncap;
    do_kick(32'hE0, "R9 index back at base");
    wait_idle("R9");
    chk(ncap == s, "R9 no bytes from an unowned descriptor", ncap - s, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++)
      mem[i] <= {pat(4*i+3), pat(4*i+2), pat(4*i+1), pat(4*i)};
    t_reset();
    t_two_buffers();
    t_single_wrap();
    t_graceful();
    t_abort();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R7 actual=hung expected=idle");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule